// File: doc/BRIEF.md
# Fixed-Length Stream Framer

The framer takes a byte stream of variable-length capture records and packs it into outer frames of a fixed size for a host link. Each input byte comes with a start-of-record flag, so the framer finds record edges without parsing any record content. Each output frame has three parts. First comes the marker byte 0x0D. Next comes a length byte equal to the payload size. Last come exactly that many payload bytes, taken from the record stream in arrival order. A record may begin in one frame and finish in the next. One frame may also hold several short records.

A single enable input starts and stops the framer. When enable is cleared, the framer discards everything it has collected, including any part of a record, and clears its counters. When enable is set again, the framer drops incoming bytes until the first byte flagged as a record start. That byte becomes the first payload byte of the next frame. A receiver that has just restarted can therefore sync on the first payload byte. It does not need to search the data for a record marker, which could be wrong because that value can also appear inside record data.

The framer never pads a frame. It first gathers a complete payload in a local buffer. Only then does it present the frame on the output, and the frame can stall there for as long as the sink applies backpressure.

Top module: `stream_framer`

## Requirements
- R1: The first byte of every output frame is the frame marker 0x0D.
- R2: The second byte of every output frame equals the parameter PAYLOAD_LEN (default 31).
- R3: After the length byte come exactly PAYLOAD_LEN payload bytes, in the order they were accepted, and then the next frame's marker. A byte flagged as a record start in the middle of a frame, or a data byte with the value 0xA0, passes through unchanged.
- R4: `outValid` stays low until a full payload of PAYLOAD_LEN bytes has been accepted. The framer never sends padding.
- R5: While `enable` is low, `inReady` and `outValid` are both low. Any bytes already collected, including part of a frame that is in progress, are discarded.
- R6: After `enable` rises, the framer accepts and drops input bytes whose `inSor` is 0. The first byte accepted with `inSor`=1 is the first payload byte of the next frame.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays stable, unless `enable` falls.
- R8: The framer does not accept input while a frame is on the output: `inReady` and `outValid` are never high together.
- R9: After reset with `enable` high, the framer is hunting for a record start: `inReady`=1 and `outValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run (1) or stop and flush (0) |
| inData | input | 8 | Record stream byte |
| inSor | input | 1 | 1 if the byte starts a record |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte accepted when high with inValid |
| outData | output | 8 | Frame byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Sink takes the output byte |

## Verification
The bench builds the framer with PAYLOAD_LEN=4. With this small size, one short byte table is enough to fill three consecutive frames. In that table, records straddle frame edges, one record sits inside a single frame, and one data byte has the value 0xA0. The same size also keeps the directed cases short. These cases stop the framer in the middle of a record and in the middle of a frame, drop stale unflagged bytes on restart, and hold the output under backpressure.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam logic [7:0] FRAME_MARK = 8'h0D;

  typedef enum logic [1:0] {SEL_MARK, SEL_LEN, SEL_PAY} outSel_e;

  typedef enum logic [2:0] {ST_HUNT, ST_FILL, ST_HEAD, ST_LEN, ST_SEND} state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic    bufWr;
    logic    ptrClr;
    logic    ptrInc;
    outSel_e outSel;
  } dpCtl_t;
endpackage

// File: rtl/framer_dp.sv
module framer_dp
  import framer_pkg::*;
#(
  parameter int PAYLOAD_LEN = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic [7:0] inData,
  output logic       ptrLast,
  output logic [7:0] outData
);
  localparam int AW = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(PAYLOAD_LEN - 1);
  localparam logic [7:0] LEN_BYTE = 8'(PAYLOAD_LEN);

  logic [7:0]    payBuf [PAYLOAD_LEN];
  logic [AW-1:0] ptr;

  // one pointer serves both filling and draining the payload buffer
  always_ff @(posedge clk) begin
    if (!rstN || ctl.ptrClr) ptr <= '0;
    else if (ctl.ptrInc)     ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctl.bufWr) payBuf[ptr] <= inData;
  end

  assign ptrLast = (ptr == LAST_IDX);

  always_comb begin
    unique case (ctl.outSel)
      SEL_MARK: outData = FRAME_MARK;
      SEL_LEN:  outData = LEN_BYTE;
      default:  outData = payBuf[ptr];
    endcase
  end
endmodule

// File: rtl/framer_ctl.sv
module framer_ctl
  import framer_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   inValid,
  input  logic   inSor,
  input  logic   outReady,
  input  logic   ptrLast,
  output logic   inReady,
  output logic   outValid,
  output dpCtl_t ctl
);
  state_e state, stateNxt;
  logic inFire, outFire;

  assign inReady  = enable && (state == ST_HUNT || state == ST_FILL);
  assign outValid = enable && (state == ST_HEAD || state == ST_LEN || state == ST_SEND);
  assign inFire   = inValid && inReady;
  assign outFire  = outValid && outReady;

  always_comb begin
    ctl.bufWr  = inFire && (state == ST_FILL || (state == ST_HUNT && inSor));
    ctl.ptrClr = !enable || (ctl.bufWr && ptrLast) ||
                 (state == ST_SEND && outFire && ptrLast);
    ctl.ptrInc = (ctl.bufWr || (state == ST_SEND && outFire)) && !ptrLast;
    unique case (state)
      ST_HEAD: ctl.outSel = SEL_MARK;
      ST_LEN:  ctl.outSel = SEL_LEN;
      default: ctl.outSel = SEL_PAY;
    endcase
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_HUNT: if (ctl.bufWr) stateNxt = ptrLast ? ST_HEAD : ST_FILL;
      ST_FILL: if (ctl.bufWr && ptrLast) stateNxt = ST_HEAD;
      ST_HEAD: if (outFire) stateNxt = ST_LEN;
      ST_LEN:  if (outFire) stateNxt = ST_SEND;
      ST_SEND: if (outFire && ptrLast) stateNxt = ST_FILL;
      default: stateNxt = ST_HUNT;
    endcase
    if (!enable) stateNxt = ST_HUNT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/stream_framer.sv
module stream_framer
  import framer_pkg::*;
#(
  parameter int PAYLOAD_LEN = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [7:0] inData,
  input  logic       inSor,
  input  logic       inValid,
  output logic       inReady,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady
);
  dpCtl_t ctl;
  logic   ptrLast;

  framer_ctl uCtl (
    .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid), .inSor(inSor),
    .outReady(outReady), .ptrLast(ptrLast), .inReady(inReady),
    .outValid(outValid), .ctl(ctl)
  );

  framer_dp #(.PAYLOAD_LEN(PAYLOAD_LEN)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .ptrLast(ptrLast), .outData(outData)
  );
endmodule

// File: rtl/framer_chk.sv
module framer_chk #(
  parameter int PAYLOAD_LEN = 31
) (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [7:0] inData,
  input logic       inSor,
  input logic       inValid,
  input logic       inReady,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady
);
  localparam logic [8:0] LAST_BEAT = 9'(PAYLOAD_LEN + 1);

  logic [8:0] beat;
  logic       hunting, firstFrame;
  logic [7:0] firstByte;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      beat       <= '0;
      hunting    <= 1'b1;
      firstFrame <= 1'b1;
      firstByte  <= '0;
    end else begin
      if (outValid && outReady) begin
        beat <= (beat == LAST_BEAT) ? 9'd0 : beat + 9'd1;
        if (beat == 9'd2) firstFrame <= 1'b0;
      end
      if (hunting && inValid && inReady && inSor) begin
        hunting   <= 1'b0;
        firstByte <= inData;
      end
    end
  end

  AST_FRAME_MARK: assert property (@(posedge clk) disable iff (!rstN)
    enable && outValid && beat == 9'd0 |-> outData == 8'h0D); // R1
  AST_LEN_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    enable && outValid && beat == 9'd1 |-> outData == 8'(PAYLOAD_LEN)); // R2
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !inReady && !outValid); // R5
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rstN)
    enable && outValid && firstFrame && beat == 9'd2 |-> outData == firstByte); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> !enable || (outValid && $stable(outData))); // R7
  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid)); // R8
endmodule

bind stream_framer framer_chk #(.PAYLOAD_LEN(PAYLOAD_LEN)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .inData(inData), .inSor(inSor),
  .inValid(inValid), .inReady(inReady), .outData(outData),
  .outValid(outValid), .outReady(outReady)
);

// File: tb/tb_stream_framer.sv
module tb_stream_framer;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 4;
  localparam int NSTIM = 12;
  // {start-of-record flag, byte}
  localparam logic [8:0] STIM [NSTIM] = '{
    {1'b1, 8'hA0}, {1'b0, 8'h02}, {1'b0, 8'h11}, {1'b0, 8'hA0},
    {1'b1, 8'hA0}, {1'b0, 8'h03}, {1'b0, 8'h22}, {1'b0, 8'h33},
    {1'b0, 8'h44}, {1'b1, 8'hA0}, {1'b0, 8'h01}, {1'b0, 8'h55}
  };

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0;
  logic [7:0] inData = '0;
  logic inSor = 1'b0, inValid = 1'b0, outReady = 1'b0;
  logic inReady, outValid;
  logic [7:0] outData;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_framer #(.PAYLOAD_LEN(PLEN)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .inData(inData), .inSor(inSor),
    .inValid(inValid), .inReady(inReady), .outData(outData),
    .outValid(outValid), .outReady(outReady)
  );

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic sor, input logic [7:0] d);
    int n = 0;
    @(negedge clk);
    inValid = 1'b1; inSor = sor; inData = d;
    while (!inReady && n < 50) begin @(negedge clk); n++; end
    if (!inReady) check(1'b0, "R6 push stuck", 8'(inReady), 8'd1);
    @(negedge clk);
    inValid = 1'b0; inSor = 1'b0;
  endtask

  task automatic pull(input logic [7:0] exp, input string req);
    int n = 0;
    @(negedge clk);
    outReady = 1'b1;
    while (!outValid && n < 50) begin @(negedge clk); n++; end
    check(outValid && outData == exp, req, outData, exp);
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic pullFrame(input logic [7:0] p0, p1, p2, p3, input string req);
    pull(8'h0D, "R1 marker");
    pull(8'(PLEN), "R2 length");
    pull(p0, req); pull(p1, req); pull(p2, req); pull(p3, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!inReady && !outValid, "R5 reset disabled", {inReady, outValid}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    rstN = 1'b0; enable = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady && !outValid, "R9 reset hunt", {inReady, outValid}, 8'd2);

    // table walk: three frames, records straddling edges (R3, R4)
    for (int f = 0; f < NSTIM / PLEN; f++) begin
      for (int b = 0; b < PLEN - 1; b++) push(STIM[f*PLEN+b][8], STIM[f*PLEN+b][7:0]);
      @(negedge clk);
      check(!outValid, "R4 no partial frame", 8'(outValid), 8'd0);
      push(STIM[f*PLEN+PLEN-1][8], STIM[f*PLEN+PLEN-1][7:0]);
      pullFrame(STIM[f*PLEN][7:0], STIM[f*PLEN+1][7:0], STIM[f*PLEN+2][7:0],
                STIM[f*PLEN+3][7:0], "R3 payload order");
    end

    // stop mid-record, restart with stale bytes ahead of the record start
    push(1'b1, 8'hA0); push(1'b0, 8'h07);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check(!inReady && !outValid, "R5 stopped quiet", {inReady, outValid}, 8'd0);
    enable = 1'b1;
    push(1'b0, 8'h99); push(1'b0, 8'h88);
    push(1'b1, 8'hA0); push(1'b0, 8'h01); push(1'b0, 8'h66); push(1'b1, 8'hA0);
    @(negedge clk);
    check(!inReady && outValid, "R8 no input while emitting", {inReady, outValid}, 8'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid && outData == 8'h0D, "R7 hold under stall", outData, 8'h0D);
    end
    pullFrame(8'hA0, 8'h01, 8'h66, 8'hA0, "R6 fresh record after restart");

    // stop in the middle of a frame on the output
    push(1'b1, 8'hA0); push(1'b0, 8'h02); push(1'b0, 8'h31); push(1'b0, 8'h32);
    pull(8'h0D, "R1 marker"); pull(8'(PLEN), "R2 length");
    enable = 1'b0;
    @(negedge clk);
    check(!outValid, "R5 frame aborted", 8'(outValid), 8'd0);
    enable = 1'b1;
    @(negedge clk);
    check(inReady && !outValid, "R5 buffer discarded", {inReady, outValid}, 8'd2);
    push(1'b0, 8'h33);
    push(1'b1, 8'hA0); push(1'b0, 8'h00); push(1'b1, 8'hA0); push(1'b0, 8'h01);
    pullFrame(8'hA0, 8'h00, 8'hA0, 8'h01, "R6 first payload is record start");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule